// File: doc/BRIEF.md
# Rank-Aware Read Request Selector

This block picks the next read to issue from the shared request buffer of one memory controller. Every buffer slot holds a pending read: a valid flag, the issuing thread, the target bank, the target row and an age that counts cycles since the slot was filled. Each cycle the selector looks at all slots whose bank is free and chooses one by strict precedence. A request that has waited at least the starvation limit comes first. Among the rest, the thread with the larger rank value wins. Next comes a request that hits the row already open in its bank. Last, the older request wins, and on equal age the lower slot index wins.

The chosen slot is freed, its bank is marked busy for a row-hit or row-conflict service time, and the bank's open row becomes the row that was accessed. An issue pulse carries the slot index, thread, bank and hit flag, so that per-thread attained-service counters can be charged. Writes live in a separate buffer. The selector watches that buffer's fill level and, with hysteresis, stops issuing reads while writes are being drained.

Top module: `rdsel_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `issueValid` and `writeDrain` are 0, and every bank's open row is marked unknown.
- R2: A request whose bank is idle issues on the second rising edge after its allocation edge. The issue pulse lasts one cycle and carries the slot index, thread and bank. The slot is then freed and never issues again until it is re-allocated.
- R3: A request whose age (edges since allocation) has reached `STARVE_CYC` beats every request whose age is below it, regardless of rank or row hit.
- R4: With equal starvation status, the request whose thread has the larger rank value wins. The rank of thread t is `rankVec[t*RANK_W +: RANK_W]`.
- R5: With equal starvation status and rank, a request to its bank's currently open row wins over a row conflict. `issueRowHit` reports which case was issued.
- R6: With all higher keys equal, the older request wins. At equal age, the lower slot index wins.
- R7: After an issue to a bank, the next issue to that bank comes no sooner than `HIT_CYC` edges later after a row hit, or `MISS_CYC` edges later after a row conflict. The first access to a bank after reset is a conflict.
- R8: After each issue, the bank's open row becomes the issued row, so a later request to that row is reported as a hit.
- R9: `writeDrain` rises one edge after `wrCount >= WR_HIGH` is seen and falls one edge after `wrCount <= WR_LOW` is seen. Between those levels it holds. No read issues on an edge where `writeDrain` was 1.
- R10: An allocation that targets a slot that is already valid is ignored, and the slot keeps its original contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Write a new read request into a slot |
| allocIdx | input | IDX_W | Target slot of the allocation |
| allocThread | input | THR_W | Thread of the new request |
| allocBank | input | BANK_W | Bank of the new request |
| allocRow | input | ROW_W | Row of the new request |
| rankVec | input | THREADS*RANK_W | Per-thread rank, larger value means higher priority |
| wrCount | input | WR_CNT_W | Current fill level of the write buffer |
| issueValid | output | 1 | One-cycle pulse: a read was issued |
| issueIdx | output | IDX_W | Slot index of the issued read |
| issueThread | output | THR_W | Thread charged with the service |
| issueBank | output | BANK_W | Bank of the issued read |
| issueRowHit | output | 1 | Issued read hit the open row |
| writeDrain | output | 1 | Write drain mode is active; reads are held |

## Verification
An issue decision is registered, so its pulse is visible after the edge that makes the choice. A freshly allocated request therefore shows up after the second edge, and a slot held back by drain mode shows up after the second edge following the drop of `wrCount`. The bench drives on falling edges and reads on the falling edge that follows each due edge. For bank occupancy it counts falling edges from one issue to the next, and that count must equal the hit or conflict service time exactly. Precedence cases are staged by holding two requests in drain mode and releasing them together, so the first pulse names the winner and the next cycle names the loser.

// File: rtl/rdsel_pkg.sv
package rdsel_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic issueEn;   // free the current winner this edge
    logic drainMode; // reads held for write drain
  } strobe_t;
endpackage

// File: rtl/rdsel_entries.sv
module rdsel_entries
  import rdsel_pkg::*;
#(
  parameter int ENTRIES    = 128,
  parameter int BANKS      = 4,
  parameter int ROW_W      = 14,
  parameter int THREADS    = 8,
  parameter int RANK_W     = 3,
  parameter int STARVE_CYC = 100000,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocValid,
  input  logic [IDX_W-1:0]          allocIdx,
  input  logic [THR_W-1:0]          allocThread,
  input  logic [BANK_W-1:0]         allocBank,
  input  logic [ROW_W-1:0]          allocRow,
  input  logic [THREADS*RANK_W-1:0] rankVec,
  input  logic                      bankIdle [BANKS],
  input  logic [ROW_W-1:0]          openRow [BANKS],
  input  logic                      openRowValid [BANKS],
  input  strobe_t                   strobe,
  output logic                      winValid,
  output logic [IDX_W-1:0]          winIdx,
  output logic [THR_W-1:0]          winThread,
  output logic [BANK_W-1:0]         winBank,
  output logic [ROW_W-1:0]          winRow,
  output logic                      winHit
);
  localparam int AGE_W  = $clog2(STARVE_CYC + 1);
  localparam int KEY_W  = AGE_W + RANK_W + 2;
  localparam int LEAVES = 1 << IDX_W;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(STARVE_CYC);

  logic              entValid  [ENTRIES];
  logic [THR_W-1:0]  entThread [ENTRIES];
  logic [BANK_W-1:0] entBank   [ENTRIES];
  logic [ROW_W-1:0]  entRow    [ENTRIES];
  logic [AGE_W-1:0]  entAge    [ENTRIES];

  // slot storage and saturating age
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN) begin
        entValid[i]  <= 1'b0;
        entThread[i] <= '0;
        entBank[i]   <= '0;
        entRow[i]    <= '0;
        entAge[i]    <= '0;
      end else if (allocValid && allocIdx == IDX_W'(i) && !entValid[i]) begin
        entValid[i]  <= 1'b1;
        entThread[i] <= allocThread;
        entBank[i]   <= allocBank;
        entRow[i]    <= allocRow;
        entAge[i]    <= '0;
      end else if (strobe.issueEn && winValid && winIdx == IDX_W'(i)) begin
        entValid[i]  <= 1'b0;
      end else if (entValid[i] && entAge[i] != AGE_MAX) begin
        entAge[i]    <= entAge[i] + 1'b1;
      end
    end
  end

  // selection tree, heap order: node n has children 2n+1 and 2n+2
  logic             nodeV   [NODES];
  logic [KEY_W-1:0] nodeKey [NODES];
  logic [IDX_W-1:0] nodeIdx [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < ENTRIES) begin : g_real
      logic              rowHit;
      logic              overLim;
      logic [RANK_W-1:0] thrRank;
      assign rowHit  = openRowValid[entBank[j]] && (openRow[entBank[j]] == entRow[j]);
      assign overLim = entAge[j] >= AGE_LIM;
      assign thrRank = rankVec[entThread[j]*RANK_W +: RANK_W];
      assign nodeV[LEAVES-1+j]   = entValid[j] && bankIdle[entBank[j]];
      assign nodeKey[LEAVES-1+j] = {overLim, thrRank, rowHit, entAge[j]};
      assign nodeIdx[LEAVES-1+j] = IDX_W'(j);
    end else begin : g_pad
      assign nodeV[LEAVES-1+j]   = 1'b0;
      assign nodeKey[LEAVES-1+j] = '0;
      assign nodeIdx[LEAVES-1+j] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic takeLeft;
    // left holds lower indices, so ties go left
    assign takeLeft = nodeV[2*n+1] &&
                      (!nodeV[2*n+2] || (nodeKey[2*n+1] >= nodeKey[2*n+2]));
    assign nodeV[n]   = nodeV[2*n+1] || nodeV[2*n+2];
    assign nodeKey[n] = takeLeft ? nodeKey[2*n+1] : nodeKey[2*n+2];
    assign nodeIdx[n] = takeLeft ? nodeIdx[2*n+1] : nodeIdx[2*n+2];
  end

  assign winValid  = nodeV[0];
  assign winIdx    = nodeIdx[0];
  assign winThread = entThread[winIdx];
  assign winBank   = entBank[winIdx];
  assign winRow    = entRow[winIdx];
  assign winHit    = nodeKey[0][AGE_W];
endmodule

// File: rtl/rdsel_ctrl.sv
module rdsel_ctrl
  import rdsel_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int ROW_W    = 14,
  parameter int HIT_CYC  = 200,
  parameter int MISS_CYC = 400,
  parameter int WR_CNT_W = 6,
  parameter int WR_HIGH  = 56,
  parameter int WR_LOW   = 16,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                winValid,
  input  logic [BANK_W-1:0]   winBank,
  input  logic [ROW_W-1:0]    winRow,
  input  logic                winHit,
  input  logic [WR_CNT_W-1:0] wrCount,
  output strobe_t             strobe,
  output logic                bankIdle [BANKS],
  output logic [ROW_W-1:0]    openRow [BANKS],
  output logic                openRowValid [BANKS]
);
  localparam int BUSY_W = $clog2(MISS_CYC + 1);
  localparam logic [BUSY_W-1:0] HIT_LOAD  = BUSY_W'(HIT_CYC - 1);
  localparam logic [BUSY_W-1:0] MISS_LOAD = BUSY_W'(MISS_CYC - 1);

  logic              drainMode;
  logic              issueEn;
  logic [BUSY_W-1:0] busyCnt [BANKS];

  assign issueEn = winValid && !drainMode;
  assign strobe  = '{issueEn: issueEn, drainMode: drainMode};

  // write drain hysteresis
  always_ff @(posedge clk) begin
    if (!rstN)
      drainMode <= 1'b0;
    else if (!drainMode && wrCount >= WR_CNT_W'(WR_HIGH))
      drainMode <= 1'b1;
    else if (drainMode && wrCount <= WR_CNT_W'(WR_LOW))
      drainMode <= 1'b0;
  end

  // per-bank occupancy and open row
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hitThis;
    assign hitThis     = issueEn && (winBank == BANK_W'(b));
    assign bankIdle[b] = (busyCnt[b] == '0);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyCnt[b]      <= '0;
        openRow[b]      <= '0;
        openRowValid[b] <= 1'b0;
      end else if (hitThis) begin
        busyCnt[b]      <= winHit ? HIT_LOAD : MISS_LOAD;
        openRow[b]      <= winRow;
        openRowValid[b] <= 1'b1;
      end else if (busyCnt[b] != '0) begin
        busyCnt[b]      <= busyCnt[b] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdsel_top.sv
module rdsel_top
  import rdsel_pkg::*;
#(
  parameter int ENTRIES    = 128,
  parameter int BANKS      = 4,
  parameter int ROW_W      = 14,
  parameter int THREADS    = 8,
  parameter int RANK_W     = 3,
  parameter int STARVE_CYC = 100000,
  parameter int HIT_CYC    = 200,
  parameter int MISS_CYC   = 400,
  parameter int WR_CNT_W   = 6,
  parameter int WR_HIGH    = 56,
  parameter int WR_LOW     = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocValid,
  input  logic [IDX_W-1:0]          allocIdx,
  input  logic [THR_W-1:0]          allocThread,
  input  logic [BANK_W-1:0]         allocBank,
  input  logic [ROW_W-1:0]          allocRow,
  input  logic [THREADS*RANK_W-1:0] rankVec,
  input  logic [WR_CNT_W-1:0]       wrCount,
  output logic                      issueValid,
  output logic [IDX_W-1:0]          issueIdx,
  output logic [THR_W-1:0]          issueThread,
  output logic [BANK_W-1:0]         issueBank,
  output logic                      issueRowHit,
  output logic                      writeDrain
);
  strobe_t           strobe;
  logic              bankIdle     [BANKS];
  logic [ROW_W-1:0]  openRow      [BANKS];
  logic              openRowValid [BANKS];
  logic              winValid;
  logic [IDX_W-1:0]  winIdx;
  logic [THR_W-1:0]  winThread;
  logic [BANK_W-1:0] winBank;
  logic [ROW_W-1:0]  winRow;
  logic              winHit;

  rdsel_entries #(
    .ENTRIES(ENTRIES), .BANKS(BANKS), .ROW_W(ROW_W), .THREADS(THREADS),
    .RANK_W(RANK_W), .STARVE_CYC(STARVE_CYC)
  ) u_entries (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocIdx(allocIdx),
    .allocThread(allocThread), .allocBank(allocBank), .allocRow(allocRow),
    .rankVec(rankVec), .bankIdle(bankIdle), .openRow(openRow),
    .openRowValid(openRowValid), .strobe(strobe), .winValid(winValid),
    .winIdx(winIdx), .winThread(winThread), .winBank(winBank),
    .winRow(winRow), .winHit(winHit)
  );

  rdsel_ctrl #(
    .BANKS(BANKS), .ROW_W(ROW_W), .HIT_CYC(HIT_CYC), .MISS_CYC(MISS_CYC),
    .WR_CNT_W(WR_CNT_W), .WR_HIGH(WR_HIGH), .WR_LOW(WR_LOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winBank(winBank),
    .winRow(winRow), .winHit(winHit), .wrCount(wrCount), .strobe(strobe),
    .bankIdle(bankIdle), .openRow(openRow), .openRowValid(openRowValid)
  );

  // registered issue report
  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueValid  <= 1'b0;
      issueIdx    <= '0;
      issueThread <= '0;
      issueBank   <= '0;
      issueRowHit <= 1'b0;
    end else begin
      issueValid <= strobe.issueEn;
      if (strobe.issueEn) begin
        issueIdx    <= winIdx;
        issueThread <= winThread;
        issueBank   <= winBank;
        issueRowHit <= winHit;
      end
    end
  end

  assign writeDrain = strobe.drainMode;
endmodule

// File: rtl/rdsel_chk.sv
module rdsel_chk #(
  parameter int ENTRIES  = 128,
  parameter int BANKS    = 4,
  parameter int HIT_CYC  = 200,
  parameter int WR_CNT_W = 6,
  parameter int WR_HIGH  = 56,
  parameter int WR_LOW   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic [WR_CNT_W-1:0] wrCount,
  input logic                writeDrain,
  input logic                issueValid,
  input logic [IDX_W-1:0]    issueIdx,
  input logic [BANK_W-1:0]   issueBank
);
  assert_no_issue_in_drain_R9: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !$past(writeDrain));

  assert_drain_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!writeDrain && wrCount >= WR_CNT_W'(WR_HIGH)) |=> writeDrain);

  assert_drain_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (writeDrain && wrCount <= WR_CNT_W'(WR_LOW)) |=> !writeDrain);

  assert_slot_freed_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !(issueValid && issueIdx == $past(issueIdx)));

  if (HIT_CYC >= 2) begin : g_busy
    assert_bank_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
      issueValid |=> !(issueValid && issueBank == $past(issueBank)));
  end
endmodule

bind rdsel_top rdsel_chk #(
  .ENTRIES(ENTRIES), .BANKS(BANKS), .HIT_CYC(HIT_CYC),
  .WR_CNT_W(WR_CNT_W), .WR_HIGH(WR_HIGH), .WR_LOW(WR_LOW)
) u_chk (
  .clk(clk), .rstN(rstN), .wrCount(wrCount), .writeDrain(writeDrain),
  .issueValid(issueValid), .issueIdx(issueIdx), .issueBank(issueBank)
);

// File: tb/rdsel_top_tb.sv
module rdsel_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8, BANKS = 4, ROW_W = 4, THREADS = 4, RANK_W = 2;
  localparam int STARVE = 30, HIT = 4, MISS = 8;
  localparam int WCW = 4, WHI = 12, WLO = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic [2:0] allocIdx = '0;
  logic [1:0] allocThread = '0;
  logic [1:0] allocBank = '0;
  logic [3:0] allocRow = '0;
  logic [7:0] rankVec = '0;
  logic [3:0] wrCount = '0;
  logic       issueValid;
  logic [2:0] issueIdx;
  logic [1:0] issueThread;
  logic [1:0] issueBank;
  logic       issueRowHit;
  logic       writeDrain;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdsel_top #(
    .ENTRIES(ENTRIES), .BANKS(BANKS), .ROW_W(ROW_W), .THREADS(THREADS),
    .RANK_W(RANK_W), .STARVE_CYC(STARVE), .HIT_CYC(HIT), .MISS_CYC(MISS),
    .WR_CNT_W(WCW), .WR_HIGH(WHI), .WR_LOW(WLO)
  ) u_dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocIdx(allocIdx),
    .allocThread(allocThread), .allocBank(allocBank), .allocRow(allocRow),
    .rankVec(rankVec), .wrCount(wrCount), .issueValid(issueValid),
    .issueIdx(issueIdx), .issueThread(issueThread), .issueBank(issueBank),
    .issueRowHit(issueRowHit), .writeDrain(writeDrain)
  );

  typedef struct packed {
    logic [1:0] thA; logic [1:0] bkA; logic [3:0] rwA;
    logic [1:0] thB; logic [1:0] bkB; logic [3:0] rwB;
    logic [7:0] ranks; logic [2:0] expIdx; logic expHit;
  } pair_t;

  // slot 0 holds A (older), slot 1 holds B; open rows tracked in comments
  localparam pair_t CASES [5] = '{
    '{2'd0, 2'd0, 4'd5, 2'd1, 2'd1, 4'd3, 8'h00, 3'd0, 1'b0}, // R6 both miss, older wins
    '{2'd0, 2'd1, 4'd7, 2'd1, 2'd0, 4'd5, 8'h00, 3'd1, 1'b1}, // R5 hit beats age
    '{2'd0, 2'd0, 4'd5, 2'd2, 2'd2, 4'd1, 8'h30, 3'd1, 1'b0}, // R4 rank beats hit
    '{2'd0, 2'd0, 4'd5, 2'd3, 2'd2, 4'd1, 8'h00, 3'd0, 1'b1}, // R6 both hit, older wins
    '{2'd1, 2'd3, 4'd2, 2'd2, 2'd1, 4'd9, 8'h24, 3'd1, 1'b0}  // R4 larger rank value wins
  };

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns at the next falling edge
  task automatic doAlloc(input int idx, input int th, input int bk, input int rw);
    allocValid = 1'b1; allocIdx = 3'(idx); allocThread = 2'(th);
    allocBank = 2'(bk); allocRow = 4'(rw);
    @(negedge clk);
    allocValid = 1'b0;
  endtask

  task automatic holdStart();
    wrCount = 4'(WHI);
    @(negedge clk);
    chkEq("R9 drain set at high mark", int'(writeDrain), 1);
  endtask

  // allocate, then count falling edges until the issue pulse
  task automatic measure(input int idx, input int th, input int bk, input int rw,
                         output int gap, output int hit);
    allocValid = 1'b1; allocIdx = 3'(idx); allocThread = 2'(th);
    allocBank = 2'(bk); allocRow = 4'(rw);
    gap = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      allocValid = 1'b0;
      gap++;
      if (issueValid) break;
    end
    hit = int'(issueRowHit);
  endtask

  initial begin
    int gap, hit, seen;
    // R1 reset state
    repeat (3) @(negedge clk);
    chkEq("R1 issueValid in reset", int'(issueValid), 0);
    chkEq("R1 writeDrain in reset", int'(writeDrain), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 issueValid after reset", int'(issueValid), 0);

    // R9 hysteresis levels
    wrCount = 4'(WHI - 1);
    @(negedge clk);
    chkEq("R9 below high mark", int'(writeDrain), 0);
    wrCount = 4'(WHI);
    @(negedge clk);
    chkEq("R9 at high mark", int'(writeDrain), 1);
    wrCount = 4'(WLO + 1);
    @(negedge clk);
    chkEq("R9 holds above low mark", int'(writeDrain), 1);
    wrCount = 4'(WLO);
    @(negedge clk);
    chkEq("R9 clears at low mark", int'(writeDrain), 0);
    wrCount = '0;
    @(negedge clk);

    // precedence table
    for (int c = 0; c < 5; c++) begin
      rankVec = CASES[c].ranks;
      holdStart();
      doAlloc(0, CASES[c].thA, CASES[c].bkA, CASES[c].rwA);
      doAlloc(1, CASES[c].thB, CASES[c].bkB, CASES[c].rwB);
      wrCount = '0;
      @(negedge clk);
      chkEq("R9 no issue while drain was set", int'(issueValid), 0);
      chkEq("R9 drain released", int'(writeDrain), 0);
      @(negedge clk);
      chkEq("R2 issue after release", int'(issueValid), 1);
      chkEq("R3/R4/R5/R6 winner slot", int'(issueIdx), int'(CASES[c].expIdx));
      chkEq("R5 winner hit flag", int'(issueRowHit), int'(CASES[c].expHit));
      @(negedge clk);
      chkEq("R2 loser issues next", int'(issueValid), 1);
      chkEq("R2 loser slot", int'(issueIdx), 1 - int'(CASES[c].expIdx));
      @(negedge clk);
      chkEq("R2 pulse ends", int'(issueValid), 0);
      repeat (12) @(negedge clk);
    end
    // open rows now: b0=5 b1=9 b2=1 b3=2

    // R3 starved low-rank conflict beats young high-rank hit
    rankVec = 8'h0C;
    holdStart();
    doAlloc(0, 0, 0, 1);
    repeat (34) @(negedge clk);
    doAlloc(1, 1, 1, 9);
    wrCount = '0;
    repeat (2) @(negedge clk);
    chkEq("R3 starved request issues", int'(issueValid), 1);
    chkEq("R3 starved request first", int'(issueIdx), 0);
    rankVec = '0;
    repeat (12) @(negedge clk);

    // R10 allocation into a valid slot is ignored
    holdStart();
    doAlloc(4, 1, 2, 1);
    doAlloc(4, 2, 3, 2);
    wrCount = '0;
    repeat (2) @(negedge clk);
    chkEq("R10 issue present", int'(issueValid), 1);
    chkEq("R10 original thread kept", int'(issueThread), 1);
    chkEq("R10 original bank kept", int'(issueBank), 2);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (issueValid) seen++;
    end
    chkEq("R10 no second request", seen, 0);

    // R7/R8 bank occupancy on bank 3 (open row 2)
    measure(2, 0, 3, 6, gap, hit);
    chkEq("R2 latency from allocation", gap, 2);
    chkEq("R7 conflict on new row", hit, 0);
    measure(3, 0, 3, 6, gap, hit);
    chkEq("R7 gap after conflict", gap, MISS);
    chkEq("R8 open row updated gives hit", hit, 1);
    measure(5, 1, 3, 6, gap, hit);
    chkEq("R7 gap after hit", gap, HIT);
    chkEq("R8 repeated hit", hit, 1);
    measure(6, 1, 3, 7, gap, hit);
    chkEq("R7 gap after hit before conflict", gap, HIT);
    chkEq("R5 different row is conflict", hit, 0);
    measure(7, 2, 3, 7, gap, hit);
    chkEq("R7 gap after conflict second", gap, MISS);
    chkEq("R8 new open row hit", hit, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule